// File: doc/BRIEF.md
# SM4 vector key-expansion unit

This block advances the SM4 key schedule by four rounds for every 128-bit element group of a vector operand. Each group holds four 32-bit round keys. The block derives four new keys from them through four chained schedule steps and writes the new keys back over the same group. A 5-bit immediate selects which set of four round constants the steps use. The byte substitution table and the round constants are generated inside the block.

A command starts with a one-cycle `start` strobe. The strobe carries the first element index, the vector length, the total element count of the register group and the tail policy. The unit then steps through whole groups, one per clock. It reads each group over a combinational read port and writes the result one cycle later through a registered port with a per-word mask. Once the body groups are done, the unit can fill the tail elements with all ones. It then pulses `done`, which tells the owner to clear its start index. A command with an unsupported element width, or with a register group smaller than one element group, gets an `illegal` pulse and changes nothing.

Top module: `sm4kx_unit`

## Requirements
- R1: After reset, `busy`, `wr_en`, `done` and `illegal` are low. No write happens until a command has been accepted.
- R2: The round-set index is `imm[2:0]`. The value of `imm[4:3]` has no effect on any written data.
- R3: Word j of a group sits at bits [32j+31:32j] and is element 4g+j, for both `rd_keys` and `wr_keys`. With input words K0..K3, step j (j = 0..3) forms b = K(j+1) ^ K(j+2) ^ K(j+3) ^ C(4r+j). It then forms K(j+4) = K(j) ^ M(T(b)), where M(s) = s ^ rotl(s,13) ^ rotl(s,23) and r is the round-set index. Each step feeds on the keys that earlier steps produced. Word j of the output is K(j+4).
- R4: Round constant C(i), for i = 0..31, is four bytes, most significant byte first. Byte k has the value (7·(4i+k)) mod 256.
- R5: T replaces each byte of the word with its value under the standard SM4 substitution box. Input keys A292FFA1, DF01FEBF, 99A12B0F, C42410CC with round set 0 produce F12186F9, 41662B61, 5A6AB19A, 7BA92077.
- R6: The unit transforms exactly the groups g with floor(vstart/4) <= g < floor(vl/4). It does not write any element below `vl` outside those groups.
- R7: When `tail_ones` is 1, every element e with vl <= e < vlmax becomes FFFFFFFF. This goes through masked writes, where `wr_mask` bit j enables word j, and no element at or above `vlmax` is touched. When `tail_ones` is 0, tail elements keep their values.
- R8: A command whose `sew` is not 3'b010 (32-bit elements), or whose `vlmax` is below 4, produces a one-cycle `illegal` pulse in the cycle after `start` is accepted. It produces no write and no `done`.
- R9: A legal command ends with a one-cycle `done` pulse. In that cycle `busy` is already low.
- R10: The first body write appears two cycles after the clock edge that accepts `start`. Body groups then follow one per cycle in rising group order. The total number of writes is the number of body groups plus the number of groups that hold at least one tail element to fill.
- R11: A `start` that arrives while `busy` is high is ignored. The running command completes with its original immediate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Command strobe, taken when idle |
| imm | input | 5 | Immediate; low three bits select the round set |
| sew | input | 3 | Element width code; 3'b010 means 32 bits |
| tail_ones | input | 1 | 1: fill tail elements with ones |
| vstart | input | IW | First element index |
| vl | input | IW | Vector length in elements |
| vlmax | input | IW | Total elements in the register group |
| busy | output | 1 | Command in progress |
| rd_grp | output | GW | Group index being read |
| rd_keys | input | 128 | Current keys of group `rd_grp` (same cycle) |
| wr_en | output | 1 | Write strobe |
| wr_grp | output | GW | Group index written |
| wr_mask | output | 4 | Per-word write enable |
| wr_keys | output | 128 | Data written |
| done | output | 1 | Command complete pulse; start index to be cleared |
| illegal | output | 1 | Command rejected pulse |

## Verification
The bench aims at start indices that are not group aligned and at lengths that stop partway through a group. An unmasked tail write would corrupt body elements that lie below `vl`, and a rounding slip would transform one group too many or too few. It sweeps the whole immediate, so a design that decodes the upper immediate bits, or that indexes the wrong round constant, fails on the group data. It also runs a known key-schedule vector to catch a broken substitution box or rotation. Further runs cover an empty body, a short register group with untouched elements above `vlmax`, both illegal conditions and a second `start` during a run. These catch a unit that skips the tail, writes on a rejected command, or restarts in mid-run.

// File: rtl/sm4kx_pkg.sv
`timescale 1ns/1ps
package sm4kx_pkg;
  localparam int KW     = 32;
  localparam int GWORDS = 4;
  localparam int GBITS  = KW * GWORDS;
  localparam logic [2:0] SEW_E32 = 3'b010;

  typedef enum logic [1:0] {
    KX_IDLE = 2'd0,
    KX_BODY = 2'd1,
    KX_TAIL = 2'd2
  } kx_state_e;

  // substitution box, one 16-byte row per high nibble, byte 0 leftmost
  function automatic logic [7:0] sbox_lookup(input logic [7:0] x);
    logic [127:0] row;
    int sh;
    case (x[7:4])
      4'h0: row = 128'hd690e9fecce13db716b614c228fb2c05;
      4'h1: row = 128'h2b679a762abe04c3aa44132649860699;
      4'h2: row = 128'h9c4250f491ef987a33540b43edcfac62;
      4'h3: row = 128'he4b31ca9c908e89580df94fa758f3fa6;
      4'h4: row = 128'h4707a7fcf37317ba83593c19e6854fa8;
      4'h5: row = 128'h686b81b27164da8bf8eb0f4b70569d35;
      4'h6: row = 128'h1e240e5e6358d1a225227c3b01217887;
      4'h7: row = 128'hd40046579fd327524c3602e7a0c4c89e;
      4'h8: row = 128'heabf8ad240c738b5a3f7f2cef96115a1;
      4'h9: row = 128'he0ae5da49b341a55ad933230f58cb1e3;
      4'ha: row = 128'h1df6e22e8266ca60c02923ab0d534e6f;
      4'hb: row = 128'hd5db3745defd8e2f03ff6a726d6c5b51;
      4'hc: row = 128'h8d1baf92bbddbc7f11d95c411f105ad8;
      4'hd: row = 128'h0ac13188a5cd7bbd2d74d012b8e5b4b0;
      4'he: row = 128'h8969974a0c96777e65b9f109c56ec684;
      4'hf: row = 128'h18f07dec3adc4d2079ee5f3ed7cb3948;
    endcase
    sh = 8 * (15 - int'(x[3:0]));
    return row[sh +: 8];
  endfunction

  // round constant: byte k = 7*(4*idx+k) mod 256, byte 0 most significant
  function automatic logic [31:0] ck_word(input logic [4:0] idx);
    logic [31:0] w;
    logic [7:0]  n;
    w = '0;
    for (int k = 0; k < 4; k++) begin
      n = {1'b0, idx, 2'b00} + 8'(k);
      w[31-8*k -: 8] = n * 8'd7;
    end
    return w;
  endfunction

  // key-schedule linear mix
  function automatic logic [31:0] lin_key(input logic [31:0] s);
    return s ^ {s[18:0], s[31:19]} ^ {s[8:0], s[31:9]};
  endfunction
endpackage

// File: rtl/sm4kx_tau.sv
`timescale 1ns/1ps
module sm4kx_tau #(
  parameter int NBYTES = 4
) (
  input  logic [8*NBYTES-1:0] din,
  output logic [8*NBYTES-1:0] dout
);
  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    assign dout[8*i +: 8] = sm4kx_pkg::sbox_lookup(din[8*i +: 8]);
  end
endmodule

// File: rtl/sm4kx_step.sv
`timescale 1ns/1ps
module sm4kx_step #(
  parameter int KW = sm4kx_pkg::KW
) (
  input  logic [KW-1:0] k0,
  input  logic [KW-1:0] k1,
  input  logic [KW-1:0] k2,
  input  logic [KW-1:0] k3,
  input  logic [KW-1:0] ck,
  output logic [KW-1:0] knew
);
  logic [KW-1:0] mix;
  logic [KW-1:0] sub;

  assign mix = k1 ^ k2 ^ k3 ^ ck;

  sm4kx_tau #(.NBYTES(KW/8)) u_tau (
    .din  (mix),
    .dout (sub)
  );

  assign knew = k0 ^ sm4kx_pkg::lin_key(sub);
endmodule

// File: rtl/sm4kx_group.sv
`timescale 1ns/1ps
module sm4kx_group #(
  parameter int KW     = sm4kx_pkg::KW,
  parameter int GWORDS = sm4kx_pkg::GWORDS,
  localparam int GBITS = KW * GWORDS
) (
  input  logic [GBITS-1:0] keys_in,
  input  logic [2:0]       rnd,
  output logic [GBITS-1:0] keys_out
);
  logic [KW-1:0] chain [0:2*GWORDS-1];

  for (genvar j = 0; j < GWORDS; j++) begin : g_load
    assign chain[j] = keys_in[KW*j +: KW];
  end

  for (genvar j = 0; j < GWORDS; j++) begin : g_step
    logic [KW-1:0] ckv;
    assign ckv = sm4kx_pkg::ck_word({rnd, 2'(j)});

    sm4kx_step #(.KW(KW)) u_step (
      .k0   (chain[j]),
      .k1   (chain[j+1]),
      .k2   (chain[j+2]),
      .k3   (chain[j+3]),
      .ck   (ckv),
      .knew (chain[j+GWORDS])
    );

    assign keys_out[KW*j +: KW] = chain[j+GWORDS];
  end
endmodule

// File: rtl/sm4kx_seq.sv
`timescale 1ns/1ps
module sm4kx_seq #(
  parameter int MAX_ELEMS = 64,
  localparam int IW = $clog2(MAX_ELEMS + 1),
  localparam int GWORDS = sm4kx_pkg::GWORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [4:0]        imm,
  input  logic [2:0]        sew,
  input  logic              tail_ones,
  input  logic [IW-1:0]     vstart,
  input  logic [IW-1:0]     vl,
  input  logic [IW-1:0]     vlmax,
  output logic              busy,
  output logic [IW-1:0]     cur_grp,
  output logic [2:0]        rnd,
  output logic              body_go,
  output logic              tail_go,
  output logic [GWORDS-1:0] tail_mask,
  output logic              done,
  output logic              illegal
);
  import sm4kx_pkg::*;

  kx_state_e     st_q;
  logic [IW-1:0] grp_q;
  logic [IW-1:0] body_end_q;
  logic [IW-1:0] vl_q;
  logic [IW-1:0] vlmax_q;
  logic          tail_q;
  logic [2:0]    rnd_q;
  logic          done_q;
  logic          ill_q;
  logic [IW:0]   tail_end;
  logic          cmd_ok;
  logic          unused_imm;

  assign unused_imm = ^imm[4:3];
  assign cmd_ok     = (sew == SEW_E32) && (vlmax >= IW'(GWORDS));
  assign tail_end   = ({1'b0, vlmax_q} + (IW+1)'(GWORDS-1)) >> 2;

  assign body_go = (st_q == KX_BODY) && (grp_q < body_end_q);
  assign tail_go = (st_q == KX_TAIL) && tail_q && ({1'b0, grp_q} < tail_end);

  for (genvar j = 0; j < GWORDS; j++) begin : g_mask
    logic [IW+1:0] eidx;
    assign eidx = {grp_q, 2'b00} + (IW+2)'(j);
    assign tail_mask[j] = (eidx >= {2'b00, vl_q}) && (eidx < {2'b00, vlmax_q});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= KX_IDLE;
      grp_q      <= '0;
      body_end_q <= '0;
      vl_q       <= '0;
      vlmax_q    <= '0;
      tail_q     <= 1'b0;
      rnd_q      <= '0;
      done_q     <= 1'b0;
      ill_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      ill_q  <= 1'b0;
      case (st_q)
        KX_IDLE: begin
          if (start) begin
            if (!cmd_ok) begin
              ill_q <= 1'b1;
            end else begin
              rnd_q      <= imm[2:0];
              vl_q       <= vl;
              vlmax_q    <= vlmax;
              tail_q     <= tail_ones;
              grp_q      <= vstart >> 2;
              body_end_q <= vl >> 2;
              st_q       <= KX_BODY;
            end
          end
        end
        KX_BODY: begin
          if (body_go) begin
            grp_q <= grp_q + 1'b1;
          end else begin
            grp_q <= body_end_q;
            st_q  <= KX_TAIL;
          end
        end
        KX_TAIL: begin
          if (tail_go) begin
            grp_q <= grp_q + 1'b1;
          end else begin
            st_q   <= KX_IDLE;
            done_q <= 1'b1;
          end
        end
        default: st_q <= KX_IDLE;
      endcase
    end
  end

  assign busy    = (st_q != KX_IDLE);
  assign cur_grp = grp_q;
  assign rnd     = rnd_q;
  assign done    = done_q;
  assign illegal = ill_q;
endmodule

// File: rtl/sm4kx_unit.sv
`timescale 1ns/1ps
module sm4kx_unit #(
  parameter int MAX_ELEMS = 64,
  localparam int IW = $clog2(MAX_ELEMS + 1),
  localparam int GW = $clog2(MAX_ELEMS / 4),
  localparam int GBITS = sm4kx_pkg::GBITS,
  localparam int GWORDS = sm4kx_pkg::GWORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [4:0]        imm,
  input  logic [2:0]        sew,
  input  logic              tail_ones,
  input  logic [IW-1:0]     vstart,
  input  logic [IW-1:0]     vl,
  input  logic [IW-1:0]     vlmax,
  output logic              busy,
  output logic [GW-1:0]     rd_grp,
  input  logic [GBITS-1:0]  rd_keys,
  output logic              wr_en,
  output logic [GW-1:0]     wr_grp,
  output logic [GWORDS-1:0] wr_mask,
  output logic [GBITS-1:0]  wr_keys,
  output logic              done,
  output logic              illegal
);
  logic [IW-1:0]     cur_grp;
  logic [2:0]        rnd;
  logic              body_go;
  logic              tail_go;
  logic [GWORDS-1:0] tail_mask;
  logic [GBITS-1:0]  next_keys;

  sm4kx_seq #(.MAX_ELEMS(MAX_ELEMS)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .imm       (imm),
    .sew       (sew),
    .tail_ones (tail_ones),
    .vstart    (vstart),
    .vl        (vl),
    .vlmax     (vlmax),
    .busy      (busy),
    .cur_grp   (cur_grp),
    .rnd       (rnd),
    .body_go   (body_go),
    .tail_go   (tail_go),
    .tail_mask (tail_mask),
    .done      (done),
    .illegal   (illegal)
  );

  sm4kx_group u_group (
    .keys_in  (rd_keys),
    .rnd      (rnd),
    .keys_out (next_keys)
  );

  assign rd_grp = cur_grp[GW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      wr_grp  <= '0;
      wr_mask <= '0;
      wr_keys <= '0;
    end else begin
      wr_en   <= body_go | (tail_go & (|tail_mask));
      wr_grp  <= cur_grp[GW-1:0];
      wr_mask <= body_go ? {GWORDS{1'b1}} : tail_mask;
      wr_keys <= body_go ? next_keys : {GBITS{1'b1}};
    end
  end
endmodule

// File: rtl/sm4kx_unit_chk.sv
`timescale 1ns/1ps
module sm4kx_unit_chk #(
  parameter int MAX_ELEMS = 64,
  localparam int GW = $clog2(MAX_ELEMS / 4)
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          wr_en,
  input logic [GW-1:0] wr_grp,
  input logic [3:0]    wr_mask,
  input logic          done,
  input logic          illegal
);
  // R1
  wr_needs_busy_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(busy));

  // R7
  wr_mask_live_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_mask != 4'b0000));

  // R8
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!wr_en && !busy && !done));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R10
  grp_order_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(wr_en)) |-> (wr_grp == GW'($past(wr_grp) + 1'b1)));

  // R11
  busy_from_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
endmodule

bind sm4kx_unit sm4kx_unit_chk #(.MAX_ELEMS(MAX_ELEMS)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .busy    (busy),
  .wr_en   (wr_en),
  .wr_grp  (wr_grp),
  .wr_mask (wr_mask),
  .done    (done),
  .illegal (illegal)
);

// File: tb/sm4kx_unit_tb.sv
`timescale 1ns/1ps
module sm4kx_unit_tb;
  localparam int ME = 64;
  localparam int IW = $clog2(ME + 1);
  localparam int GW = $clog2(ME / 4);
  localparam int NG = ME / 4;

  localparam logic [127:0] SB_ROWS [16] = '{
    128'hd690e9fecce13db716b614c228fb2c05, 128'h2b679a762abe04c3aa44132649860699,
    128'h9c4250f491ef987a33540b43edcfac62, 128'he4b31ca9c908e89580df94fa758f3fa6,
    128'h4707a7fcf37317ba83593c19e6854fa8, 128'h686b81b27164da8bf8eb0f4b70569d35,
    128'h1e240e5e6358d1a225227c3b01217887, 128'hd40046579fd327524c3602e7a0c4c89e,
    128'heabf8ad240c738b5a3f7f2cef96115a1, 128'he0ae5da49b341a55ad933230f58cb1e3,
    128'h1df6e22e8266ca60c02923ab0d534e6f, 128'hd5db3745defd8e2f03ff6a726d6c5b51,
    128'h8d1baf92bbddbc7f11d95c411f105ad8, 128'h0ac13188a5cd7bbd2d74d012b8e5b4b0,
    128'h8969974a0c96777e65b9f109c56ec684, 128'h18f07dec3adc4d2079ee5f3ed7cb3948
  };

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic [4:0]     imm = '0;
  logic [2:0]     sew = 3'b010;
  logic           tail_ones = 1'b0;
  logic [IW-1:0]  vstart = '0;
  logic [IW-1:0]  vl = '0;
  logic [IW-1:0]  vlmax = '0;
  logic           busy;
  logic [GW-1:0]  rd_grp;
  logic [127:0]   rd_keys;
  logic           wr_en;
  logic [GW-1:0]  wr_grp;
  logic [3:0]     wr_mask;
  logic [127:0]   wr_keys;
  logic           done;
  logic           illegal;

  logic [127:0] mem   [NG];
  logic [127:0] exp_m [NG];
  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  assign rd_keys = mem[rd_grp];

  sm4kx_unit #(.MAX_ELEMS(ME)) u_dut (
    .clk(clk), .rst(rst), .start(start), .imm(imm), .sew(sew),
    .tail_ones(tail_ones), .vstart(vstart), .vl(vl), .vlmax(vlmax),
    .busy(busy), .rd_grp(rd_grp), .rd_keys(rd_keys), .wr_en(wr_en),
    .wr_grp(wr_grp), .wr_mask(wr_mask), .wr_keys(wr_keys),
    .done(done), .illegal(illegal)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exv);
    end
  endtask

  function automatic logic [31:0] ref_sub(input logic [31:0] x);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) begin
      logic [7:0] v;
      v = x[8*b +: 8];
      r[8*b +: 8] = SB_ROWS[v[7:4]][8*(15 - int'(v[3:0])) +: 8];
    end
    return r;
  endfunction

  function automatic logic [31:0] ref_ck(input int i);
    logic [31:0] w;
    for (int k = 0; k < 4; k++) w[31-8*k -: 8] = 8'(((4*i + k) * 7) % 256);
    return w;
  endfunction

  function automatic logic [127:0] ref_next(input logic [127:0] kin, input int r);
    logic [31:0] k [8];
    logic [127:0] o;
    for (int j = 0; j < 4; j++) k[j] = kin[32*j +: 32];
    for (int j = 0; j < 4; j++) begin
      logic [31:0] t;
      t = ref_sub(k[j+1] ^ k[j+2] ^ k[j+3] ^ ref_ck(4*r + j));
      k[j+4] = k[j] ^ t ^ {t[18:0], t[31:19]} ^ {t[8:0], t[31:9]};
    end
    for (int j = 0; j < 4; j++) o[32*j +: 32] = k[j+4];
    return o;
  endfunction

  task automatic do_op(input logic [4:0] op_imm, input logic [2:0] op_sew, input int op_vs,
                       input int op_vl, input int op_vm, input bit op_tail, input bit restrike,
                       input bit kat, input int seed, input string tag);
    bit legal;
    int nb, nt, k, first, nw;
    bit seen_done, seen_ill;
    int ill_k;
    for (int g = 0; g < NG; g++)
      for (int j = 0; j < 4; j++)
        mem[g][32*j +: 32] = 32'((seed * 64 + g * 4 + j + 1) * 32'h9E3779B1) ^ 32'h5A3C_0000;
    if (kat) mem[0] = {32'hc42410cc, 32'h99a12b0f, 32'hdf01febf, 32'ha292ffa1};
    legal = (op_sew == 3'b010) && (op_vm >= 4);
    nb = 0; nt = 0;
    for (int g = 0; g < NG; g++) begin
      bit any_t;
      exp_m[g] = mem[g];
      if (legal && g >= op_vs / 4 && g < op_vl / 4) begin
        exp_m[g] = ref_next(mem[g], int'(op_imm[2:0]));
        nb++;
      end
      any_t = 1'b0;
      for (int j = 0; j < 4; j++)
        if (legal && op_tail && (4*g + j) >= op_vl && (4*g + j) < op_vm) begin
          exp_m[g][32*j +: 32] = 32'hFFFF_FFFF;
          any_t = 1'b1;
        end
      if (any_t) nt++;
    end
    @(negedge clk);
    imm = op_imm; sew = op_sew; vstart = IW'(op_vs); vl = IW'(op_vl);
    vlmax = IW'(op_vm); tail_ones = op_tail; start = 1'b1;
    k = 0; first = -1; nw = 0; seen_done = 0; seen_ill = 0; ill_k = -1;
    while (!seen_done && !seen_ill && k < 400) begin
      @(negedge clk);
      k++;
      if (k == 1) start = 1'b0;
      if (restrike && k == 3) begin start = 1'b1; imm = op_imm ^ 5'd5; end
      if (restrike && k == 4) start = 1'b0;
      if (wr_en) begin
        for (int j = 0; j < 4; j++)
          if (wr_mask[j]) mem[wr_grp][32*j +: 32] = wr_keys[32*j +: 32];
        if (first < 0) first = k;
        nw++;
      end
      if (done) seen_done = 1'b1;
      if (illegal) begin seen_ill = 1'b1; ill_k = k; end
    end
    if (legal)
      chk(seen_done && !seen_ill, "R9 done for legal command", {30'd0, seen_done, seen_ill}, 32'd2);
    else
      chk(seen_ill && ill_k == 1 && nw == 0 && !seen_done, "R8 illegal pulse, no write",
          32'(ill_k), 32'd1);
    @(negedge clk);
    chk(!done && !busy, "R9 done is one cycle, idle after", {30'd0, done, busy}, 32'd0);
    if (legal) begin
      if (nb > 0) chk(first == 2, "R10 first write latency", 32'(first), 32'd2);
      chk(nw == nb + nt, "R10 write count", 32'(nw), 32'(nb + nt));
    end
    for (int g = 0; g < NG; g++)
      for (int j = 0; j < 4; j++) begin
        string req;
        int e;
        e = 4*g + j;
        if (tag != "") req = tag;
        else if (legal && g >= op_vs / 4 && g < op_vl / 4) req = "R3 body group";
        else if (legal && op_tail && e >= op_vl && e < op_vm) req = "R7 tail ones";
        else if (!legal) req = "R8 untouched";
        else req = "R6 untouched";
        chk(mem[g][32*j +: 32] === exp_m[g][32*j +: 32], req,
            mem[g][32*j +: 32], exp_m[g][32*j +: 32]);
      end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int g = 0; g < NG; g++) mem[g] = '0;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !wr_en && !done && !illegal, "R1 reset outputs",
        {28'd0, busy, wr_en, done, illegal}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !wr_en && !done && !illegal, "R1 idle after reset",
        {28'd0, busy, wr_en, done, illegal}, 32'd0);

    // R5: known schedule vector, round set 0
    do_op(5'd0, 3'b010, 0, 4, 64, 1'b0, 1'b0, 1'b1, 1, "");
    chk(mem[0][31:0]   == 32'hf12186f9, "R5 key word 0", mem[0][31:0],   32'hf12186f9);
    chk(mem[0][63:32]  == 32'h41662b61, "R5 key word 1", mem[0][63:32],  32'h41662b61);
    chk(mem[0][95:64]  == 32'h5a6ab19a, "R5 key word 2", mem[0][95:64],  32'h5a6ab19a);
    chk(mem[0][127:96] == 32'h7ba92077, "R5 key word 3", mem[0][127:96], 32'h7ba92077);

    // R2 / R4: whole immediate range
    for (int i = 0; i < 32; i++)
      do_op(5'(i), 3'b010, 0, 64, 64, 1'b0, 1'b0, 1'b0, 2 + i, (i >= 8) ? "R2 upper imm" : "R4 round set");

    // R6 / R7: start index and length sweep
    for (int l = 0; l <= 64; l += 3)
      for (int s = 0; s <= l; s += 5)
        do_op(5'(l + s), 3'b010, s, l, 64, 1'(l % 2), 1'b0, 1'b0, 100 + l * 7 + s, "");

    // R7: short register group, elements above vlmax untouched
    do_op(5'd3, 3'b010, 1, 30, 32, 1'b1, 1'b0, 1'b0, 501, "");
    do_op(5'd6, 3'b010, 0, 13, 20, 1'b0, 1'b0, 1'b0, 502, "");

    // R8: rejected commands
    do_op(5'd1, 3'b011, 0, 64, 64, 1'b1, 1'b0, 1'b0, 601, "");
    do_op(5'd1, 3'b010, 0, 3, 3, 1'b1, 1'b0, 1'b0, 602, "");

    // R11: second start during a run
    do_op(5'd2, 3'b010, 0, 64, 64, 1'b1, 1'b1, 1'b0, 701, "R11 restart ignored");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule